// File: doc/BRIEF.md
# Packed SIMD Add/Subtract Unit

This unit treats each of two 32-bit operands as a vector of four 8-bit lanes or two 16-bit lanes and performs lane-wise addition or subtraction. There are four flavours of arithmetic: signed wrapping, unsigned wrapping, signed saturating and signed halving. There are also two cross-lane forms on halfwords, in wrapping and saturating variants. These forms pair the low half of A with the high half of B, and the high half of A with the low half of B.

Wrapping operations leave a persistent 4-bit greater-or-equal flag register, one bit per byte. The flags describe the untruncated lane results. A later select operation merges A and B byte by byte under control of those flags. The result and flag registers update on the clock edge after a valid strobe. Operation decode upstream, the register file and multiply work sit outside this block.

Top module: `simd_addsub_unit`

## Requirements
- R1: The opcode is 5 bits. Codes 0..7 are 8-bit lanes and codes 8..15 are the same operations on 16-bit lanes, in this order: signed add, signed sub, unsigned add, unsigned sub, saturating add, saturating sub, halving add, halving sub. 16 is add-sub-exchange, 17 is sub-add-exchange, 18 and 19 are their saturating forms, and 20 is select. The result shows on `out_result` one clock after the edge that samples `in_valid`.
- R2: Lane 0 is bits 7:0 and lane 3 is bits 31:24. 8-bit wrapping add and sub give each lane's sum or difference modulo 256, so 127+2 gives 0x81 and 1-5 gives 0xFC.
- R3: 16-bit wrapping add and sub give each halfword's result modulo 65536, so 0x7FFF+2 gives 0x8001. Halfword 0 is bits 15:0.
- R4: Saturating operations clamp each lane to its signed range: 127 or -128 for bytes, 32767 or -32768 for halfwords.
- R5: Halving operations return the full-precision signed sum or difference shifted right by one with the sign kept, so 1-5 gives -2 and -128-1 gives -65.
- R6: Add-sub-exchange gives low = A.lo - B.hi and high = A.hi + B.lo. Sub-add-exchange gives low = A.lo + B.hi and high = A.hi - B.lo. The saturating variants clamp as in R4.
- R7: For signed wrapping add, sub and exchange operations, each flag bit is 1 when its lane's untruncated result is zero or positive.
- R8: For unsigned add, a flag bit is the lane's carry out. For unsigned subtract, a flag bit is 1 when A >= B.
- R9: In 16-bit lane mode, a halfword's flag is written to both flag bits of its two bytes: halfword 0 to bits 1:0 and halfword 1 to bits 3:2.
- R10: Saturating, halving and select operations leave `out_ge` unchanged.
- R11: Select returns byte i of A when flag bit i is 1 and byte i of B otherwise, using the flags held before the select.
- R12: `out_sat` is 1 for exactly the one cycle after a saturating operation in which any lane clamped, and 0 at all other times.
- R13: Reset clears `out_result`, `out_ge` and `out_sat` to zero. A cycle without `in_valid`, or with an unused opcode (21..31), leaves `out_result` and `out_ge` unchanged and `out_sat` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation strobe |
| in_op | input | 5 | Operation code (R1) |
| in_a | input | 32 | Operand A |
| in_b | input | 32 | Operand B |
| out_result | output | 32 | Registered lane result |
| out_ge | output | 4 | Greater-or-equal flag register, one bit per byte |
| out_sat | output | 1 | One-cycle pulse: a saturating lane clamped |

## Verification
The bench pushes lanes across the signed limits in both directions. A design that kept only the truncated lane result would get the flags for 127+2 and -128-1 wrong, and would mis-round halving of -129. The exchange forms use asymmetric operands so that swapping the wrong halves, or applying add and subtract to the wrong lanes, changes the result. Unsigned carry and borrow flags, the duplication of flags in halfword mode, flag retention across saturating and halving operations, the one-cycle width of the saturation pulse, and select both before and after a reset are each checked. Any of these done wrong shows up as wrong bytes or wrong flags at the ports.

// File: rtl/simd_pkg.sv
`timescale 1ns/1ps
package simd_pkg;

    localparam int WORD_W   = 32;
    localparam int BYTE_W   = 8;
    localparam int HALF_W   = 16;
    localparam int N_BYTES  = WORD_W / BYTE_W;
    localparam int N_HALVES = WORD_W / HALF_W;
    localparam int BPH      = HALF_W / BYTE_W;   // bytes per halfword
    localparam int OP_W     = 5;

    // Code order matters: decode_op slices the code arithmetically.
    typedef enum logic [OP_W-1:0] {
        OP_ADD8   = 5'd0,  OP_SUB8   = 5'd1,  OP_UADD8  = 5'd2,  OP_USUB8  = 5'd3,
        OP_QADD8  = 5'd4,  OP_QSUB8  = 5'd5,  OP_HADD8  = 5'd6,  OP_HSUB8  = 5'd7,
        OP_ADD16  = 5'd8,  OP_SUB16  = 5'd9,  OP_UADD16 = 5'd10, OP_USUB16 = 5'd11,
        OP_QADD16 = 5'd12, OP_QSUB16 = 5'd13, OP_HADD16 = 5'd14, OP_HSUB16 = 5'd15,
        OP_XADS   = 5'd16, OP_XSAD   = 5'd17, OP_QXADS  = 5'd18, OP_QXSAD  = 5'd19,
        OP_PICK   = 5'd20
    } simd_op_e;

    typedef enum logic [1:0] {
        K_WRAP = 2'd0,
        K_SAT  = 2'd1,
        K_HALF = 2'd2
    } lane_kind_e;

    typedef struct packed {
        logic       legal;
        logic       wide;     // 16-bit lanes
        logic       sgn;
        logic       sub_lo;   // subtract in lane 0 (all lanes in 8-bit mode)
        logic       sub_hi;   // subtract in upper halfword
        logic       swap;     // exchange halves of B
        lane_kind_e kind;
        logic       ge_wr;
        logic       sel;
    } op_ctrl_t;

    function automatic op_ctrl_t decode_op(input logic [OP_W-1:0] op);
        op_ctrl_t c;
        c      = '0;
        c.kind = K_WRAP;
        if (op < 5'd16) begin
            c.legal  = 1'b1;
            c.wide   = op[3];
            c.sub_lo = op[0];
            c.sub_hi = op[0];
            case (op[2:1])
                2'b00:   begin c.sgn = 1'b1; c.kind = K_WRAP; c.ge_wr = 1'b1; end
                2'b01:   begin c.sgn = 1'b0; c.kind = K_WRAP; c.ge_wr = 1'b1; end
                2'b10:   begin c.sgn = 1'b1; c.kind = K_SAT;  end
                default: begin c.sgn = 1'b1; c.kind = K_HALF; end
            endcase
        end else if (op < 5'd20) begin
            c.legal  = 1'b1;
            c.wide   = 1'b1;
            c.swap   = 1'b1;
            c.sgn    = 1'b1;
            c.kind   = op[1] ? K_SAT : K_WRAP;
            c.ge_wr  = ~op[1];
            c.sub_lo = ~op[0];
            c.sub_hi = op[0];
        end else if (op == 5'd20) begin
            c.legal = 1'b1;
            c.sel   = 1'b1;
        end
        return c;
    endfunction

endpackage

// File: rtl/simd_lane.sv
`timescale 1ns/1ps
module simd_lane
    import simd_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    input  logic         sgn,
    input  lane_kind_e   kind,
    output logic [W-1:0] res,
    output logic         ge,
    output logic         clip
);
    localparam int XW = W + 2;
    localparam logic signed [XW-1:0] SMAX = {3'b000, {(W-1){1'b1}}};
    localparam logic signed [XW-1:0] SMIN = {3'b111, {(W-1){1'b0}}};

    logic signed [XW-1:0] ax, bx, full;
    logic                 over, under;

    always_comb begin
        ax    = sgn ? {{2{a[W-1]}}, a} : {2'b00, a};
        bx    = sgn ? {{2{b[W-1]}}, b} : {2'b00, b};
        full  = sub ? (ax - bx) : (ax + bx);
        over  = full > SMAX;
        under = full < SMIN;
        case (kind)
            K_SAT:   res = over ? SMAX[W-1:0] : (under ? SMIN[W-1:0] : full[W-1:0]);
            K_HALF:  res = full[W:1];
            default: res = full[W-1:0];
        endcase
        // signed or subtract: non-negative full result; unsigned add: carry
        ge   = (sgn || sub) ? ~full[XW-1] : full[W];
        clip = (kind == K_SAT) && (over || under);
    end
endmodule

// File: rtl/simd_byte_pick.sv
`timescale 1ns/1ps
module simd_byte_pick #(
    parameter int N = 4,
    parameter int W = 8
) (
    input  logic [N*W-1:0] a,
    input  logic [N*W-1:0] b,
    input  logic [N-1:0]   flags,
    output logic [N*W-1:0] y
);
    for (genvar i = 0; i < N; i++) begin : g_byte
        assign y[i*W +: W] = flags[i] ? a[i*W +: W] : b[i*W +: W];
    end
endmodule

// File: rtl/simd_addsub_unit.sv
`timescale 1ns/1ps
module simd_addsub_unit
    import simd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [OP_W-1:0]   in_op,
    input  logic [WORD_W-1:0] in_a,
    input  logic [WORD_W-1:0] in_b,
    output logic [WORD_W-1:0] out_result,
    output logic [N_BYTES-1:0] out_ge,
    output logic              out_sat
);
    op_ctrl_t ctl;
    assign ctl = decode_op(in_op);

    logic [N_BYTES-1:0][BYTE_W-1:0]  r8;
    logic [N_BYTES-1:0]              ge8, clip8;
    logic [N_HALVES-1:0][HALF_W-1:0] r16;
    logic [N_HALVES-1:0]             ge16, clip16;
    logic [N_BYTES-1:0]              ge16x;
    logic [WORD_W-1:0]               pick_y;

    // byte lanes
    for (genvar i = 0; i < N_BYTES; i++) begin : g_b8
        simd_lane #(.W(BYTE_W)) u_lane (
            .a    (in_a[i*BYTE_W +: BYTE_W]),
            .b    (in_b[i*BYTE_W +: BYTE_W]),
            .sub  (ctl.sub_lo),
            .sgn  (ctl.sgn),
            .kind (ctl.kind),
            .res  (r8[i]),
            .ge   (ge8[i]),
            .clip (clip8[i])
        );
    end

    // halfword lanes, B halves optionally exchanged
    for (genvar j = 0; j < N_HALVES; j++) begin : g_h16
        localparam int JX = N_HALVES - 1 - j;
        logic [HALF_W-1:0] bsel;
        assign bsel = ctl.swap ? in_b[JX*HALF_W +: HALF_W] : in_b[j*HALF_W +: HALF_W];
        simd_lane #(.W(HALF_W)) u_lane (
            .a    (in_a[j*HALF_W +: HALF_W]),
            .b    (bsel),
            .sub  ((j == 0) ? ctl.sub_lo : ctl.sub_hi),
            .sgn  (ctl.sgn),
            .kind (ctl.kind),
            .res  (r16[j]),
            .ge   (ge16[j]),
            .clip (clip16[j])
        );
    end

    for (genvar k = 0; k < N_BYTES; k++) begin : g_gex
        assign ge16x[k] = ge16[k / BPH];
    end

    simd_byte_pick #(.N(N_BYTES), .W(BYTE_W)) u_pick (
        .a     (in_a),
        .b     (in_b),
        .flags (out_ge),
        .y     (pick_y)
    );

    logic [WORD_W-1:0]  nxt_res;
    logic [N_BYTES-1:0] nxt_ge;
    logic               any_clip;

    always_comb begin
        if (ctl.sel)       nxt_res = pick_y;
        else if (ctl.wide) nxt_res = r16;
        else               nxt_res = r8;
        nxt_ge   = ctl.wide ? ge16x : ge8;
        any_clip = ctl.wide ? (|clip16) : (|clip8);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_result <= '0;
            out_ge     <= '0;
            out_sat    <= 1'b0;
        end else begin
            out_sat <= 1'b0;
            if (in_valid && ctl.legal) begin
                out_result <= nxt_res;
                if (ctl.ge_wr) out_ge <= nxt_ge;
                out_sat <= (ctl.kind == K_SAT) && !ctl.sel && any_clip;
            end
        end
    end

    // ---------------- assertions ----------------
    p_ge_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (in_valid && ctl.legal && !ctl.ge_wr) |=> $stable(out_ge));

    p_ge_pair_r9: assert property (@(posedge clk) disable iff (rst)
        (in_valid && ctl.legal && ctl.wide && ctl.ge_wr)
        |=> (out_ge[1] == out_ge[0]) && (out_ge[3] == out_ge[2]));

    p_sat_src_r12: assert property (@(posedge clk) disable iff (rst)
        out_sat |-> ($past(in_valid) && ($past(ctl.kind) == K_SAT)));

    p_idle_hold_r13: assert property (@(posedge clk) disable iff (rst)
        !(in_valid && ctl.legal) |=> ($stable(out_result) && $stable(out_ge) && !out_sat));

    for (genvar k = 0; k < N_BYTES; k++) begin : g_chk_pick
        p_pick_byte_r11: assert property (@(posedge clk) disable iff (rst)
            (in_valid && ctl.sel) |=>
            (out_result[k*BYTE_W +: BYTE_W] ==
             ($past(out_ge[k]) ? $past(in_a[k*BYTE_W +: BYTE_W])
                               : $past(in_b[k*BYTE_W +: BYTE_W]))));
    end
endmodule

// File: tb/test_simd_addsub_unit.sv
`timescale 1ns/1ps
module test_simd_addsub_unit;
    import simd_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [4:0]  in_op = 5'd0;
    logic [31:0] in_a = '0, in_b = '0;
    logic [31:0] out_result;
    logic [3:0]  out_ge;
    logic        out_sat;

    always #2 clk = ~clk;   // 250 MHz

    simd_addsub_unit i_simd_addsub_unit (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op),
        .in_a(in_a), .in_b(in_b),
        .out_result(out_result), .out_ge(out_ge), .out_sat(out_sat)
    );

    typedef struct packed {
        logic [4:0]  op;
        logic [31:0] a;
        logic [31:0] b;
        logic [31:0] res;
        logic [3:0]  ge;
        logic        sat;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 23;
    localparam vec_t VECS [NV] = '{
        '{5'd0,  32'h7F030201, 32'h02FBFF02, 32'h81FE0103, 4'b1011, 1'b0, 4'd2 },  // R2 R7
        '{5'd1,  32'h80057F01, 32'h0105FF05, 32'h7F0080FC, 4'b0110, 1'b0, 4'd7 },  // R7 full-precision sign
        '{5'd2,  32'hFF801001, 32'h01802002, 32'h00003003, 4'b1100, 1'b0, 4'd8 },  // R8 carry
        '{5'd3,  32'h01030201, 32'h02030405, 32'hFF00FEFC, 4'b0100, 1'b0, 4'd8 },  // R8 borrow
        '{5'd20, 32'hAABBCCDD, 32'h11223344, 32'h11BB3344, 4'b0100, 1'b0, 4'd11},  // R11
        '{5'd4,  32'h7F801001, 32'h01FFF002, 32'h7F800003, 4'b0100, 1'b1, 4'd4 },  // R4 R10 R12
        '{5'd5,  32'h05050505, 32'h01020304, 32'h04030201, 4'b0100, 1'b0, 4'd12},  // R12 no clamp
        '{5'd6,  32'h80030201, 32'hFF030405, 32'hBF030303, 4'b0100, 1'b0, 4'd5 },  // R5
        '{5'd7,  32'h04030201, 32'h02030405, 32'h0100FFFE, 4'b0100, 1'b0, 4'd5 },  // R5
        '{5'd8,  32'h00017FFF, 32'hFFF00002, 32'hFFF18001, 4'b0011, 1'b0, 4'd3 },  // R3 R9
        '{5'd9,  32'h0014000A, 32'hFFF60014, 32'h001EFFF6, 4'b1100, 1'b0, 4'd9 },  // R9
        '{5'd10, 32'h00018000, 32'h00018000, 32'h00020000, 4'b0011, 1'b0, 4'd8 },  // R8 16-bit carry
        '{5'd11, 32'h00050003, 32'h00030005, 32'h0002FFFE, 4'b1100, 1'b0, 4'd8 },  // R8
        '{5'd12, 32'h80007FFF, 32'hFFFF0001, 32'h80007FFF, 4'b1100, 1'b1, 4'd4 },  // R4 R10
        '{5'd13, 32'h0014000A, 32'hFFF60014, 32'h001EFFF6, 4'b1100, 1'b0, 4'd10},  // R10
        '{5'd14, 32'h00020001, 32'h00040005, 32'h00030003, 4'b1100, 1'b0, 4'd5 },  // R5
        '{5'd15, 32'h00020001, 32'h00040005, 32'hFFFFFFFE, 4'b1100, 1'b0, 4'd5 },  // R5
        '{5'd16, 32'h00020001, 32'h00030002, 32'h0004FFFE, 4'b1100, 1'b0, 4'd6 },  // R6
        '{5'd17, 32'h00020001, 32'h00030005, 32'hFFFD0004, 4'b0011, 1'b0, 4'd6 },  // R6
        '{5'd18, 32'h7FFF0001, 32'h00020002, 32'h7FFFFFFF, 4'b0011, 1'b1, 4'd6 },  // R6 saturating
        '{5'd19, 32'h7FFF0001, 32'h00020002, 32'h7FFD0003, 4'b0011, 1'b0, 4'd6 },  // R6
        '{5'd20, 32'hAABBCCDD, 32'h11223344, 32'h1122CCDD, 4'b0011, 1'b0, 4'd11},  // R11
        '{5'd5,  32'h80808080, 32'h01010101, 32'h80808080, 4'b0011, 1'b1, 4'd4 }   // R4 low limit
    };

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic issue(input logic [4:0] op, input logic [31:0] a, input logic [31:0] b);
        @(negedge clk);
        in_valid = 1'b1; in_op = op; in_a = a; in_b = b;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] hold_r;
        logic [3:0]  hold_g;
        repeat (3) @(negedge clk);
        // R13 reset state
        chk("R13", "reset result", out_result, 32'h0);
        chk("R13", "reset ge", {28'h0, out_ge}, 32'h0);
        chk("R13", "reset sat", {31'h0, out_sat}, 32'h0);
        rst = 1'b0;

        for (int v = 0; v < NV; v++) begin
            string rq;
            rq = $sformatf("R%0d vec%0d", VECS[v].req, v);
            issue(VECS[v].op, VECS[v].a, VECS[v].b);   // R1 one-cycle latency
            chk(rq, "result", out_result, VECS[v].res);
            chk(rq, "ge", {28'h0, out_ge}, {28'h0, VECS[v].ge});
            chk(rq, "sat", {31'h0, out_sat}, {31'h0, VECS[v].sat});
            // idle cycle: R12 pulse ends, R13 values held
            @(negedge clk);
            chk("R12", "sat after idle", {31'h0, out_sat}, 32'h0);
            chk("R13", "idle result", out_result, VECS[v].res);
            chk("R13", "idle ge", {28'h0, out_ge}, {28'h0, VECS[v].ge});
        end

        // R13 unused opcode changes nothing
        hold_r = out_result;
        hold_g = out_ge;
        issue(5'd25, 32'h7F7F7F7F, 32'h7F7F7F7F);
        chk("R13", "unused op result", out_result, hold_r);
        chk("R13", "unused op ge", {28'h0, out_ge}, {28'h0, hold_g});
        chk("R13", "unused op sat", {31'h0, out_sat}, 32'h0);

        // R13 reset mid-run clears flags, then R11 select picks all of B
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        chk("R13", "re-reset ge", {28'h0, out_ge}, 32'h0);
        chk("R13", "re-reset result", out_result, 32'h0);
        issue(5'd20, 32'hAABBCCDD, 32'h11223344);
        chk("R11", "select after reset", out_result, 32'h11223344);

        // R1 signed add with all lanes negative results: ge 0000
        issue(5'd0, 32'h80808080, 32'hFFFFFFFF);
        chk("R7", "neg add result", out_result, 32'h7F7F7F7F);
        chk("R7", "neg add ge", {28'h0, out_ge}, 32'h0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule